// File: doc/BRIEF.md
# LIN Header Transmitter with Fault Injection

This block puts a LIN frame header onto a single serial transmit line. When a host raises a start strobe, the block takes a 6-bit frame identifier and sends three fields at the bit rate set by an external tick. The first field is a long dominant break with a recessive delimiter. The second is a sync byte. The third is the protected identifier, which is the identifier with two parity bits added. Byte fields use the usual asynchronous framing.

To test a receiver's error detection, the block can corrupt chosen parts of the header on purpose. Four independent selects cover four faults: the sync value, the sync stop bit, the high parity bit of the identifier, and the identifier stop bit. The selects take effect only when a global enable is set and the fault channel index supplied with them equals this instance's own channel number. The block samples the selects together with the identifier when it accepts a start, and holds them for the whole header.

Top module: `lin_hdr_tx`

## Requirements
- R1: Out of reset, and whenever `busy` is low, `tx` is high (recessive) and `done` is low.
- R2: After a start is accepted, `tx` stays high until the next `bit_tick`. It then drives low for exactly `BREAK_BITS` tick periods, followed by high for `DELIM_BITS` tick periods.
- R3: Each byte field lasts ten tick periods. It has a low start bit, then eight data bits with bit 0 sent first, then a stop bit that is high unless a fault lowers it.
- R4: Without faults, the sync byte is 0x55. The identifier byte carries ID[5:0] in bits 5..0. Bit 6 is P0 = ID0^ID1^ID2^ID4. Bit 7 is P1 = NOT(ID1^ID3^ID4^ID5).
- R5: `done` is high for exactly one clock, in the first cycle after the identifier stop bit ends. `busy` is low in that same cycle.
- R6: A start that arrives while `busy` is high is ignored. The header in progress, including its identifier, is not changed, and no further header follows it.
- R7: Fault selects act only when `flt_en` is high and `flt_chan` equals the parameter `CHAN_ID` at the moment the start is accepted. Otherwise the header is the normal one.
- R8: `flt_sync_val` makes the sync byte 0x00.
- R9: `flt_sync_stop` drives the stop bit after the sync byte low.
- R10: `flt_parity` sends P1 as ID1^ID3^ID4^ID5 without inversion. P0 is never changed.
- R11: `flt_pid_stop` drives the stop bit after the identifier byte low.
- R12: The fault selects are independent, so any combination applies to one header. All selects are sampled when the start is accepted, and later changes do not affect the header in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | One-clock pulse marking each bit boundary |
| start | input | 1 | Header request strobe |
| frame_id | input | 6 | Frame identifier |
| flt_en | input | 1 | Global fault enable |
| flt_chan | input | CHAN_W | Channel index that fault injection targets |
| flt_sync_val | input | 1 | Select: sync byte sent as 0x00 |
| flt_sync_stop | input | 1 | Select: sync stop bit low |
| flt_parity | input | 1 | Select: P1 sent without inversion |
| flt_pid_stop | input | 1 | Select: identifier stop bit low |
| tx | output | 1 | Serial line, idles high |
| busy | output | 1 | Header in progress |
| done | output | 1 | One-clock pulse when the header completes |

## Verification
The bench builds the block with `BREAK_BITS=14`, `DELIM_BITS=2` and `CHAN_ID=9`, and issues a tick every four clocks. Because the break and delimiter lengths differ from their defaults, a counter terminal value that is hard-wired or off by one shows up as a shifted bit stream. The non-zero channel number gives a real mismatch case for the channel gate. The short tick period keeps each header near 150 clocks, which leaves room for every single fault, a combined fault, and a mid-header restart attempt.

// File: rtl/lin_hdr_pkg.sv
package lin_hdr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARM,
    ST_BRK,
    ST_DLM,
    ST_SYN,
    ST_PID
  } hdr_st_e;

  typedef struct packed {
    logic sync_val;
    logic sync_stop;
    logic parity;
    logic pid_stop;
  } flt_sel_t;

  localparam logic [7:0] SYNC_PATTERN = 8'h55;
  localparam int         FIELD_BITS   = 10;

endpackage

// File: rtl/lin_hdr_capture.sv
module lin_hdr_capture
  import lin_hdr_pkg::*;
#(
  parameter int CHAN_W  = 5,
  parameter int CHAN_ID = 0,
  parameter int ID_W    = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [ID_W-1:0]   frame_id,
  input  logic              flt_en,
  input  logic [CHAN_W-1:0] flt_chan,
  input  flt_sel_t          flt_req,
  output logic [ID_W-1:0]   id_q,
  output flt_sel_t          flt_q
);

  logic            chan_hit;
  logic [ID_W-1:0] id_d;
  flt_sel_t        flt_d;

  assign chan_hit = flt_en && (flt_chan == CHAN_W'(CHAN_ID));

  always_comb begin
    id_d  = id_q;
    flt_d = flt_q;
    if (take) begin
      id_d  = frame_id;
      flt_d = chan_hit ? flt_req : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_q  <= '0;
      flt_q <= '0;
    end else begin
      id_q  <= id_d;
      flt_q <= flt_d;
    end
  end

  // R7: a start taken without enable and channel match carries no fault
  a_r7_gate_off: assert property (@(posedge clk) disable iff (!rst_n)
    take && !(flt_en && flt_chan == CHAN_W'(CHAN_ID)) |=> flt_q == '0);

  // R12: captured selects change only when a start is accepted
  a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(flt_q) && $stable(id_q));

endmodule

// File: rtl/lin_pid_calc.sv
module lin_pid_calc
  import lin_hdr_pkg::*;
(
  input  logic [5:0] id,
  input  logic       flip_p1,
  output logic [7:0] pid
);

  logic p0;
  logic p1_raw;

  always_comb begin
    p0     = id[0] ^ id[1] ^ id[2] ^ id[4];
    p1_raw = id[1] ^ id[3] ^ id[4] ^ id[5];
    pid    = {(flip_p1 ? p1_raw : ~p1_raw), p0, id};
  end

endmodule

// File: rtl/lin_hdr_seq.sv
module lin_hdr_seq
  import lin_hdr_pkg::*;
#(
  parameter int BREAK_BITS = 13,
  parameter int DELIM_BITS = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       take,
  input  logic [7:0] sync_byte,
  input  logic [7:0] pid_byte,
  input  logic       sync_stop_bad,
  input  logic       pid_stop_bad,
  output logic       tx,
  output logic       busy,
  output logic       done
);

  localparam int MAXB0 = (BREAK_BITS > DELIM_BITS) ? BREAK_BITS : DELIM_BITS;
  localparam int MAXB  = (MAXB0 > FIELD_BITS) ? MAXB0 : FIELD_BITS;
  localparam int CNT_W = $clog2(MAXB + 1);

  hdr_st_e          st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done_q, done_d;

  function automatic logic field_bit(input logic [7:0] b, input logic stop_bad,
                                     input logic [CNT_W-1:0] idx);
    logic [CNT_W-1:0] k;
    k = idx - 1'b1;
    if (idx == '0)                              return 1'b0;
    else if (idx >= CNT_W'(FIELD_BITS - 1))     return !stop_bad;
    else                                        return b[k[2:0]];
  endfunction

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    done_d = 1'b0;
    case (st_q)
      ST_IDLE: if (take) st_d = ST_ARM;
      ST_ARM: if (tick) begin
        st_d  = ST_BRK;
        cnt_d = '0;
      end
      ST_BRK: if (tick) begin
        if (cnt_q == CNT_W'(BREAK_BITS - 1)) begin
          st_d  = ST_DLM;
          cnt_d = '0;
        end else cnt_d = cnt_q + 1'b1;
      end
      ST_DLM: if (tick) begin
        if (cnt_q == CNT_W'(DELIM_BITS - 1)) begin
          st_d  = ST_SYN;
          cnt_d = '0;
        end else cnt_d = cnt_q + 1'b1;
      end
      ST_SYN: if (tick) begin
        if (cnt_q == CNT_W'(FIELD_BITS - 1)) begin
          st_d  = ST_PID;
          cnt_d = '0;
        end else cnt_d = cnt_q + 1'b1;
      end
      ST_PID: if (tick) begin
        if (cnt_q == CNT_W'(FIELD_BITS - 1)) begin
          st_d   = ST_IDLE;
          cnt_d  = '0;
          done_d = 1'b1;
        end else cnt_d = cnt_q + 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  always_comb begin
    case (st_q)
      ST_BRK:  tx = 1'b0;
      ST_SYN:  tx = field_bit(sync_byte, sync_stop_bad, cnt_q);
      ST_PID:  tx = field_bit(pid_byte, pid_stop_bad, cnt_q);
      default: tx = 1'b1;
    endcase
  end

  assign busy = (st_q != ST_IDLE);
  assign done = done_q;

  // R2: break field is dominant throughout
  a_r2_break_low: assert property (@(posedge clk) disable iff (!rst_n)
    st_q == ST_BRK |-> !tx);

  // R3: the line level changes only at a bit boundary while a header runs
  a_r3_bit_hold: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !tick |=> $stable(tx));

  // R5: completion pulse is one clock wide
  a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R5: completion pulse follows a busy cycle and coincides with idle
  a_r5_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && $past(busy));

endmodule

// File: rtl/lin_hdr_tx.sv
module lin_hdr_tx
  import lin_hdr_pkg::*;
#(
  parameter int BREAK_BITS = 13,
  parameter int DELIM_BITS = 1,
  parameter int CHAN_W     = 5,
  parameter int CHAN_ID    = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic              start,
  input  logic [5:0]        frame_id,
  input  logic              flt_en,
  input  logic [CHAN_W-1:0] flt_chan,
  input  logic              flt_sync_val,
  input  logic              flt_sync_stop,
  input  logic              flt_parity,
  input  logic              flt_pid_stop,
  output logic              tx,
  output logic              busy,
  output logic              done
);

  logic       take;
  logic [5:0] id_q;
  flt_sel_t   flt_req, flt_q;
  logic [7:0] pid_byte, sync_byte;

  assign take    = start && !busy;
  assign flt_req = '{sync_val: flt_sync_val, sync_stop: flt_sync_stop,
                     parity: flt_parity, pid_stop: flt_pid_stop};

  lin_hdr_capture #(
    .CHAN_W (CHAN_W),
    .CHAN_ID(CHAN_ID),
    .ID_W   (6)
  ) u_cap (
    .clk     (clk),
    .rst_n   (rst_n),
    .take    (take),
    .frame_id(frame_id),
    .flt_en  (flt_en),
    .flt_chan(flt_chan),
    .flt_req (flt_req),
    .id_q    (id_q),
    .flt_q   (flt_q)
  );

  lin_pid_calc u_pid (
    .id     (id_q),
    .flip_p1(flt_q.parity),
    .pid    (pid_byte)
  );

  assign sync_byte = flt_q.sync_val ? 8'h00 : SYNC_PATTERN;

  lin_hdr_seq #(
    .BREAK_BITS(BREAK_BITS),
    .DELIM_BITS(DELIM_BITS)
  ) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick         (bit_tick),
    .take         (take),
    .sync_byte    (sync_byte),
    .pid_byte     (pid_byte),
    .sync_stop_bad(flt_q.sync_stop),
    .pid_stop_bad (flt_q.pid_stop),
    .tx           (tx),
    .busy         (busy),
    .done         (done)
  );

  // R1: idle line is recessive
  a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> tx);

  // R6: a start while busy leaves the captured identifier alone
  a_r6_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start |=> $stable(id_q));

endmodule

// File: tb/sim_lin_hdr_tx.sv
`timescale 1ns/1ps
module sim_lin_hdr_tx;

  localparam int BRK  = 14;
  localparam int DLM  = 2;
  localparam int CHAN = 9;
  localparam int TD   = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_tick = 1'b0;
  logic       start = 1'b0;
  logic [5:0] frame_id = '0;
  logic       flt_en = 1'b0;
  logic [4:0] flt_chan = '0;
  logic       flt_sync_val = 1'b0, flt_sync_stop = 1'b0;
  logic       flt_parity = 1'b0, flt_pid_stop = 1'b0;
  logic       tx, busy, done;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  typedef struct { logic lvl; string tag; } exp_t;
  exp_t q[$];

  always #2.5 clk = ~clk;

  lin_hdr_tx #(.BREAK_BITS(BRK), .DELIM_BITS(DLM), .CHAN_W(5), .CHAN_ID(CHAN)) u0 (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .start(start), .frame_id(frame_id),
    .flt_en(flt_en), .flt_chan(flt_chan), .flt_sync_val(flt_sync_val),
    .flt_sync_stop(flt_sync_stop), .flt_parity(flt_parity), .flt_pid_stop(flt_pid_stop),
    .tx(tx), .busy(busy), .done(done));

  int tcnt = 0;
  always @(negedge clk) begin
    bit_tick <= (tcnt == TD - 1);
    tcnt = (tcnt == TD - 1) ? 0 : tcnt + 1;
  end

  task automatic chk(input logic act, input logic exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic push(input logic lvl, input string tag);
    exp_t e;
    e.lvl = lvl;
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic push_byte(input logic [7:0] b, input logic stop, input string ctx,
                           input string dtag, input string stag);
    push(1'b0, {ctx, " R3 start"});
    for (int i = 0; i < 8; i++) push(b[i], {ctx, " ", dtag});
    push(stop, {ctx, " ", stag});
  endtask

  // sel order: [3] sync value, [2] sync stop, [1] parity, [0] identifier stop
  task automatic run_hdr(input logic [5:0] id, input logic en, input logic [4:0] chan,
                         input logic [3:0] sel, input bit disturb, input string ctx);
    logic       gate;
    logic [3:0] eff;
    logic [7:0] sb, pb;
    logic       p0, p1;
    gate = en && (chan == 5'(CHAN));
    eff  = gate ? sel : 4'b0000;
    sb   = eff[3] ? 8'h00 : 8'h55;
    p0   = id[0] ^ id[1] ^ id[2] ^ id[4];
    p1   = ~(id[1] ^ id[3] ^ id[4] ^ id[5]);
    if (eff[1]) p1 = ~p1;
    pb   = {p1, p0, id};
    for (int i = 0; i < BRK; i++) push(1'b0, {ctx, " R2 break"});
    for (int i = 0; i < DLM; i++) push(1'b1, {ctx, " R2 delim"});
    push_byte(sb, !eff[2], ctx, eff[3] ? "R8 sync" : "R4 sync",
              eff[2] ? "R9 sync stop" : "R3 sync stop");
    push_byte(pb, !eff[0], ctx, eff[1] ? "R10 pid" : "R4 pid",
              eff[0] ? "R11 pid stop" : "R3 pid stop");
    @(negedge clk);
    frame_id = id; flt_en = en; flt_chan = chan;
    {flt_sync_val, flt_sync_stop, flt_parity, flt_pid_stop} = sel;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (disturb) begin
      repeat (30) @(negedge clk);
      frame_id = ~id; flt_en = 1'b1; flt_chan = 5'(CHAN);
      {flt_sync_val, flt_sync_stop, flt_parity, flt_pid_stop} = ~sel;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // monitor: pops one expected level per bit, sampled half a clock into each bit
  initial begin
    forever begin
      @(negedge clk);
      if (busy && !tx) begin
        int n;
        n = BRK + DLM + 20;
        for (int i = 0; i < n; i++) begin
          if (q.size() == 0) begin
            total++; bad++;
            $display("FAIL R2 unexpected bit actual=%b expected=none", tx);
          end else begin
            exp_t e;
            e = q.pop_front();
            chk(tx, e.lvl, e.tag);
          end
          if (i < n - 1) repeat (TD) @(negedge clk);
        end
        repeat (TD) @(negedge clk);
        chk(done, 1'b1, "R5 done pulse");
        chk(busy, 1'b0, "R5 busy low with done");
        @(negedge clk);
        chk(done, 1'b0, "R5 done one clock");
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(tx, 1'b1, "R1 reset tx");
    chk(busy, 1'b0, "R1 reset busy");
    chk(done, 1'b0, "R1 reset done");

    run_hdr(6'h3C, 1'b0, 5'(CHAN), 4'hF, 0, "R7 enable off");
    run_hdr(6'h15, 1'b1, 5'(CHAN), 4'h0, 0, "R4 plain");
    run_hdr(6'h2A, 1'b1, 5'd3,     4'hF, 0, "R7 channel miss");
    run_hdr(6'h01, 1'b1, 5'(CHAN), 4'h8, 0, "R8");
    run_hdr(6'h22, 1'b1, 5'(CHAN), 4'h4, 0, "R9");
    run_hdr(6'h10, 1'b1, 5'(CHAN), 4'h2, 0, "R10");
    run_hdr(6'h3F, 1'b1, 5'(CHAN), 4'h2, 0, "R10 all ones");
    run_hdr(6'h07, 1'b1, 5'(CHAN), 4'h1, 0, "R11");
    run_hdr(6'h2D, 1'b1, 5'(CHAN), 4'hF, 1, "R12 combined R6");
    run_hdr(6'h19, 1'b1, 5'(CHAN), 4'h0, 1, "R12 late change R6");

    repeat (60) @(negedge clk);
    chk(busy, 1'b0, "R6 no queued header");
    chk(tx, 1'b1, "R1 idle after run");
    total++;
    if (q.size() != 0) begin
      bad++;
      $display("FAIL R3 leftover bits actual=%0d expected=0", q.size());
    end
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule